// File: doc/BRIEF.md
# Equivalent-Time Sampling Strobe Generator

This block produces a slow sample strobe for an ADC so that a repetitive signal faster than the real-time sampling limit can still be recorded. It watches a squared copy of the input signal. Once every N input periods it issues one strobe, and each strobe lands later after its input edge than the one before it by a programmable step of reference-clock ticks. The samples it triggers therefore sweep across one input period, and after a set number of points the sweep starts again at zero delay. Capture logic uses the point index that comes with each strobe to place the sample at its equivalent-time address.

All timing runs on one fast reference clock. The squared input is asynchronous and is synchronised first. The enable, the cycle interval, the point count and the step are synchronous to the reference clock. They are changed only while the block is disabled. The step is normally chosen as period × f_ref / points, so the points span one input period evenly.

Top module: `ets_sampler`

## Requirements
- R1: While `rst_ni` is low, `strobe_o` and `valid_o` are 0 and `idx_o` is 0.
- R2: While `en_ni` is high, no strobe is produced, the input-cycle count is held at zero and the sweep goes back to point 0 with zero delay. After `en_ni` returns low, the first strobe is point 0.
- R3: With `en_ni` low and N = `n_i` ≥ 4, strobe k (k = 0, 1, ...) is caused by input rising edge number N·(k+1), counting edges seen since enable.
- R4: A value of `n_i` below 4 is treated as 4.
- R5: The strobe of point p rises on reference edge 5 + p·`m_i`, where the first edge that samples `sig_i` high, after its rise, counts as edge 1.
- R6: Every strobe stays high for exactly two input periods, measured in reference cycles.
- R7: The point index runs 0, 1, ..., `pts_i`−1 and then wraps to 0. At the wrap the delay also returns to 0, so the delay of point p is p·`m_i`.
- R8: A `pts_i` of 0 or 1 gives point 0 and zero delay for every strobe.
- R9: `valid_o` is high for exactly the one cycle in which `strobe_o` rises. `idx_o` takes the strobe's point index at that edge and keeps it while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_i | input | 1 | Squared input signal, asynchronous |
| en_ni | input | 1 | Enable, active low |
| n_i | input | N_W (4) | Input cycles between strobes, minimum 4 |
| pts_i | input | PT_W (8) | Points per sweep |
| m_i | input | M_W (8) | Delay step per point, in reference ticks |
| strobe_o | output | 1 | Delayed sample strobe |
| valid_o | output | 1 | One-cycle flag on the strobe's rising edge |
| idx_o | output | PT_W (8) | Point index of the current strobe |

## Verification
The bench places each strobe relative to the input edge that caused it. A design that used the delay of the wrong pulse, or that added the step before the first point, would show an offset shifted by one step. It counts input edges from enable to each strobe, which catches a design that fires one cycle early or that skips the clamp of N to 4. It runs past the end of each sweep, which catches an off-by-one at the wrap, and it checks that a disable or a reset in the middle of a sweep makes the next strobe point 0. It also measures every strobe's width, so a design whose falling-edge delay differs from its rising-edge delay would show a strobe that is too wide or too narrow.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam int N_MIN     = 4;  // two-cycle pulse needs headroom in the interval
  localparam int EDGE_RISE = 0;
  localparam int EDGE_FALL = 1;
  localparam int NUM_EDGES = 2;
endpackage

// File: rtl/ets_edge_sync.sv
module ets_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sig_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ets_interval.sv
module ets_interval #(
  parameter int N_W   = 4,
  parameter int N_MIN = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           rise_i,
  input  logic [N_W-1:0] n_i,
  output logic           p_rise_o,
  output logic           p_fall_o
);
  localparam logic [N_W-1:0] N_MIN_V = N_W'(N_MIN);

  logic [N_W-1:0] n_eff, cnt_q;
  logic           pulse_q, wrap;

  assign n_eff    = (n_i < N_MIN_V) ? N_MIN_V : n_i;
  assign wrap     = (cnt_q == n_eff - N_W'(1));
  assign p_rise_o = rise_i & wrap;
  // pulse spans two input cycles: ends on the second edge after wrap
  assign p_fall_o = rise_i & pulse_q & (cnt_q == N_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q   <= wrap ? '0 : cnt_q + N_W'(1);
      pulse_q <= wrap | (pulse_q & (cnt_q == '0));
    end
  end
endmodule

// File: rtl/ets_sweep.sv
module ets_sweep #(
  parameter int PT_W  = 8,
  parameter int M_W   = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [PT_W-1:0]  pts_i,
  input  logic [M_W-1:0]   m_i,
  output logic [DLY_W-1:0] dly_o,
  output logic [PT_W-1:0]  idx_o
);
  logic [DLY_W-1:0] dly_q;
  logic [PT_W-1:0]  idx_q;
  logic             last;

  assign last = (pts_i <= PT_W'(1)) || (idx_q == pts_i - PT_W'(1));

  // advances on the pulse fall, so the value is stable for the next pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      dly_q <= '0;
      idx_q <= '0;
    end else if (step_i) begin
      if (last) begin
        dly_q <= '0;
        idx_q <= '0;
      end else begin
        dly_q <= dly_q + DLY_W'(m_i);
        idx_q <= idx_q + PT_W'(1);
      end
    end
  end

  assign dly_o = dly_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/ets_edge_delay.sv
module ets_edge_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ev_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             busy_q, fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fire_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (ev_i) begin
        cnt_q  <= dly_i;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          fire_q <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - DLY_W'(1);
        end
      end
    end
  end

  assign fire_o = fire_q;
endmodule

// File: rtl/ets_sampler.sv
module ets_sampler
  import ets_pkg::*;
#(
  parameter int N_W         = 4,
  parameter int PT_W        = 8,
  parameter int M_W         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sig_i,
  input  logic            en_ni,
  input  logic [N_W-1:0]  n_i,
  input  logic [PT_W-1:0] pts_i,
  input  logic [M_W-1:0]  m_i,
  output logic            strobe_o,
  output logic            valid_o,
  output logic [PT_W-1:0] idx_o
);
  localparam int DLY_W = PT_W + M_W;

  logic                 clr, in_rise, p_rise, p_fall;
  logic [DLY_W-1:0]     dly;
  logic [PT_W-1:0]      sw_idx, pend_idx_q;
  logic [NUM_EDGES-1:0] ev, fire;
  logic                 strobe_q, valid_q;
  logic [PT_W-1:0]      idx_q;

  assign clr = en_ni;

  ets_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig_i),
    .rise_o (in_rise)
  );

  ets_interval #(.N_W(N_W), .N_MIN(N_MIN)) i_interval (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .rise_i   (in_rise),
    .n_i      (n_i),
    .p_rise_o (p_rise),
    .p_fall_o (p_fall)
  );

  ets_sweep #(.PT_W(PT_W), .M_W(M_W), .DLY_W(DLY_W)) i_sweep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (p_fall),
    .pts_i  (pts_i),
    .m_i    (m_i),
    .dly_o  (dly),
    .idx_o  (sw_idx)
  );

  assign ev[EDGE_RISE] = p_rise;
  assign ev[EDGE_FALL] = p_fall;

  // one delay counter per pulse edge, both loaded with the same delay
  for (genvar g = 0; g < NUM_EDGES; g++) begin : g_edge
    ets_edge_delay #(.DLY_W(DLY_W)) i_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .ev_i   (ev[g]),
      .dly_i  (dly),
      .fire_o (fire[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_idx_q <= '0;
      strobe_q   <= 1'b0;
      valid_q    <= 1'b0;
      idx_q      <= '0;
    end else if (clr) begin
      pend_idx_q <= '0;
      strobe_q   <= 1'b0;
      valid_q    <= 1'b0;
      idx_q      <= '0;
    end else begin
      valid_q <= 1'b0;
      if (p_rise) pend_idx_q <= sw_idx;
      if (fire[EDGE_RISE]) begin
        strobe_q <= 1'b1;
        valid_q  <= 1'b1;
        idx_q    <= pend_idx_q;
      end else if (fire[EDGE_FALL]) begin
        strobe_q <= 1'b0;
      end
    end
  end

  assign strobe_o = strobe_q;
  assign valid_o  = valid_q;
  assign idx_o    = idx_q;
endmodule

// File: rtl/ets_sampler_chk.sv
module ets_sampler_chk #(
  parameter int PT_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_ni,
  input logic [PT_W-1:0] pts_i,
  input logic            strobe_o,
  input logic            valid_o,
  input logic [PT_W-1:0] idx_o,
  input logic [1:0]      fire_i
);
  a_r9_valid_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (strobe_o && !$past(strobe_o)));

  a_r9_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && $past(strobe_o)) |-> $stable(idx_o));

  a_r2_quiet_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> (!strobe_o && !valid_o));

  a_r8_one_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pts_i <= PT_W'(1)) && valid_o) |-> (idx_o == '0));

  a_r6_edges_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fire_i));
endmodule

bind ets_sampler ets_sampler_chk #(.PT_W(PT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_ni    (en_ni),
  .pts_i    (pts_i),
  .strobe_o (strobe_o),
  .valid_o  (valid_o),
  .idx_o    (idx_o),
  .fire_i   (fire)
);

// File: tb/test_ets_sampler.sv
module test_ets_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 64;   // input period in reference cycles
  localparam int NV         = 6;
  // {n, pts, m, strobes}
  localparam logic [31:0] VEC [NV] = '{
    {8'd4, 8'd8,  8'd6,  8'd10},
    {8'd5, 8'd3,  8'd17, 8'd7},
    {8'd2, 8'd4,  8'd9,  8'd5},
    {8'd6, 8'd1,  8'd20, 8'd4},
    {8'd4, 8'd0,  8'd33, 8'd3},
    {8'd4, 8'd16, 8'd3,  8'd18}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sig_i = 1'b0;
  logic       en_ni = 1'b1;
  logic [3:0] n_i = 4'd4;
  logic [7:0] pts_i = 8'd1;
  logic [7:0] m_i = 8'd0;
  logic       strobe_o, valid_o;
  logic [7:0] idx_o;

  int total = 0, bad = 0;
  int cyc = 0, ph = 0, last_rise = 0, rise_num = 0, rise_cyc = 0;
  int k_rise = 0, k_fall = 0;
  int cfg_n = 4, cfg_pts = 1, cfg_m = 0;
  bit sig_run = 1'b0, strobe_prev = 1'b0, done = 1'b0;
  logic [7:0] idx_held = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ets_sampler i_ets_sampler (
    .clk_i(clk), .rst_ni(rst_ni), .sig_i(sig_i), .en_ni(en_ni),
    .n_i(n_i), .pts_i(pts_i), .m_i(m_i),
    .strobe_o(strobe_o), .valid_o(valid_o), .idx_o(idx_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int n_eff();
    return (cfg_n < 4) ? 4 : cfg_n;
  endfunction
  function automatic int p_eff();
    return (cfg_pts <= 1) ? 1 : cfg_pts;
  endfunction

  // monitor first, then input generator, all at the falling edge
  always @(negedge clk) begin
    bit rose, fell;
    bit sig_nxt;
    cyc++;
    rose = strobe_o && !strobe_prev;
    fell = !strobe_o && strobe_prev;
    if (valid_o !== rose) check(1'b0, "R9 valid", int'(valid_o), int'(rose));
    if (strobe_o && strobe_prev && idx_o !== idx_held)
      check(1'b0, "R9 idx hold", int'(idx_o), int'(idx_held));
    if (rose) begin
      int p;
      p = k_rise % p_eff();
      // R2: after enable or reset the sweep starts at point 0 (k_rise reset by bench)
      check(cyc - last_rise == 5 + p * cfg_m, "R5 offset", cyc - last_rise, 5 + p * cfg_m);
      check(rise_num == n_eff() * (k_rise + 1), (cfg_n < 4) ? "R4 edge count" : "R3 edge count",
            rise_num, n_eff() * (k_rise + 1));
      check(int'(idx_o) == p, (cfg_pts <= 1) ? "R8 index" : "R7 index", int'(idx_o), p);
      idx_held = idx_o;
      rise_cyc = cyc;
      k_rise++;
    end
    if (fell) begin
      check(cyc - rise_cyc == 2 * P, "R6 width", cyc - rise_cyc, 2 * P);
      k_fall++;
    end
    strobe_prev = strobe_o;
    if (sig_run) begin
      sig_nxt = (ph < P/2);
      ph = (ph == P-1) ? 0 : ph + 1;
    end else begin
      sig_nxt = 1'b0;
      ph = 0;
    end
    if (sig_nxt && !sig_i) begin
      last_rise = cyc;
      rise_num++;
    end
    sig_i = sig_nxt;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic configure(input int n, input int pts, input int m);
    sig_run = 1'b0;
    idle(10);
    en_ni = 1'b1;
    cfg_n = n; cfg_pts = pts; cfg_m = m;
    n_i = 4'(n); pts_i = 8'(pts); m_i = 8'(m);
    idle(5);
    en_ni = 1'b0;
    k_rise = 0; k_fall = 0; rise_num = 0;
    idle(5);
  endtask

  task automatic run_strobes(input int ns);
    int guard = 0;
    sig_run = 1'b1;
    while (k_fall < ns && guard < 40 * P * (ns + 2)) begin
      @(negedge clk);
      guard++;
    end
    check(k_fall == ns, "R3 strobe count", k_fall, ns);
    sig_run = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(strobe_o == 1'b0 && valid_o == 1'b0 && idx_o == '0, "R1 reset", int'(idx_o), 0);
    rst_ni = 1'b1;
    idle(3);

    // R2: disabled, input running, nothing comes out
    n_i = 4'd4; pts_i = 8'd8; m_i = 8'd6;
    sig_run = 1'b1;
    idle(12 * P);
    sig_run = 1'b0;
    check(k_rise == 0 && strobe_o == 1'b0, "R2 disabled", k_rise, 0);
    check(idx_o == '0, "R2 idx", int'(idx_o), 0);

    for (int v = 0; v < NV; v++) begin
      configure(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]));
      run_strobes(int'(VEC[v][7:0]));
    end

    // R1: reset mid-sweep clears index, sweep restarts at point 0
    configure(4, 8, 6);
    run_strobes(3);
    idle(4);
    rst_ni = 1'b0;
    idle(2);
    check(idx_o == '0 && strobe_o == 1'b0 && valid_o == 1'b0, "R1 mid reset", int'(idx_o), 0);
    rst_ni = 1'b1;
    k_rise = 0; k_fall = 0; rise_num = 0;
    idle(5);
    run_strobes(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule